// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block holds the fetch address pair of a scalar core whose control transfers take effect after one delay-slot instruction. In every cycle the instruction at `pc` is considered executed. The address of its delay slot is `pc_next`. The decoder supplies the transfer kind, the condition result, a 16-bit word offset, a 26-bit absolute word target, a register-held target and an exception request. From these the block produces the next address pair. It also produces a flag that cancels the following instruction, the return address for exceptions, and a one-cycle pulse that drops the core out of user mode.

Branch-likely transfers that are not taken cancel their delay slot. An exception cancels whatever follows it and sends fetch to a fixed handler address. The exception return address carries a marker bit when the faulting instruction sat in a delay slot. In the first cycle after reset, the block inspects the word fetched from address zero. It may relocate the start address when that word carries a known boot signature.

Top module: `dspc_sequencer`

## Requirements
- R1: Outside the boot cycle, each clock moves `pc` to the old `pc_next`. When no redirect applies, `pc_next` grows by 4. Redirects are absent for kind codes 0, 5, 6 and 7, and for kinds 1 and 2 with `br_cond` low.
- R2: Kind 1 (conditional) with `br_cond` high sets `pc_next` to the old `pc_next` plus the sign-extended `br_imm` times 4, with bits 1:0 cleared. `pc_next` bits 1:0 are always zero.
- R3: Kind 2 (likely) with `br_cond` high redirects as in R2. With `br_cond` low, `pc_next` grows by 4 and `annul` is high in the following cycle.
- R4: Kind 3 (absolute jump) sets `pc_next` to bits 31:28 of the old `pc_next` (the delay-slot address), then `jmp_tgt`, then two zero bits.
- R5: Kind 4 (register jump) sets `pc_next` to `jmp_reg` with bits 1:0 cleared.
- R6: A live `exc_req` sets `epc` to `pc`+4. Bit 1 of `epc` is set when `pc_next` differed from `pc`+4. `pc_next` becomes 0x3C, and `annul` and `mode_clr` are high for the next cycle. The exception wins over any transfer in the same cycle.
- R7: While `annul` is high, the current instruction's kind, condition and exception request have no effect. `pc_next` grows by 4, and `annul` and `mode_clr` are low in the next cycle.
- R8: The first clock after reset is a boot cycle. If `insn_word[31:8]` equals 0x3C1C10, `pc` becomes 0x10000000 and `pc_next` becomes 0x10000004. Otherwise the pair stays 0/4.
- R9: During reset `pc`=0, `pc_next`=4, `annul`=0, `epc`=0 and `mode_clr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_word | input | 32 | Word fetched at `pc`, inspected in the boot cycle |
| br_kind | input | 3 | Transfer kind of the instruction at `pc` |
| br_cond | input | 1 | Condition result for kinds 1 and 2 |
| br_imm | input | 16 | Signed word offset |
| jmp_tgt | input | 26 | Absolute word target |
| jmp_reg | input | 32 | Register-held target |
| exc_req | input | 1 | Exception raised by the instruction at `pc` |
| pc | output | 32 | Address of the instruction executing now |
| pc_next | output | 32 | Address of the following instruction |
| annul | output | 1 | Instruction at `pc` is cancelled |
| epc | output | 32 | Exception return address |
| mode_clr | output | 1 | One-cycle pulse after an exception |

## Verification
Two functions can fall in the same cycle. First, an exception can arrive together with a taken or untaken transfer, so the exception priority rule competes with the branch redirect. Second, an exception or a likely-miss can land on an instruction that is already annulled. The sweep applies every kind, with both condition values and with the exception request both low and high. The earlier steps leave the sequencer in annulled, delay-slot and sequential states. Each step is compared with an arithmetic model kept in the bench, which gives the exception precedence over the branch and gives the annul flag precedence over both.

// File: rtl/dspc_pkg.sv
package dspc_pkg;
  localparam int unsigned ADDR_W = 32;

  typedef enum logic [2:0] {
    BK_SEQ    = 3'd0,
    BK_COND   = 3'd1,
    BK_LIKELY = 3'd2,
    BK_JABS   = 3'd3,
    BK_JREG   = 3'd4
  } bkind_e;

  // word-offset relative target, word aligned
  function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] base,
                                                   input logic [15:0] off);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W-18){off[15]}}, off, 2'b00};
    return (base + ext) & ~ADDR_W'(3);
  endfunction

  // absolute region target keeping the top nibble of the slot address
  function automatic logic [ADDR_W-1:0] abs_target(input logic [ADDR_W-1:0] slot,
                                                   input logic [25:0] tgt);
    return {slot[ADDR_W-1:ADDR_W-4], tgt, 2'b00};
  endfunction

  // return address with delay-slot marker in bit 1
  function automatic logic [ADDR_W-1:0] ret_addr(input logic [ADDR_W-1:0] cur,
                                                 input logic [ADDR_W-1:0] nxt);
    logic [ADDR_W-1:0] seq;
    seq = cur + ADDR_W'(4);
    return seq | ((nxt != seq) ? ADDR_W'(2) : ADDR_W'(0));
  endfunction
endpackage

// File: rtl/dspc_target.sv
module dspc_target
  import dspc_pkg::*;
(
  input  logic [2:0]        kind,
  input  logic              cond,
  input  logic [15:0]       imm,
  input  logic [25:0]       jt,
  input  logic [ADDR_W-1:0] jreg,
  input  logic [ADDR_W-1:0] slot_addr,
  output logic              redirect,
  output logic              likely_miss,
  output logic [ADDR_W-1:0] tgt
);
  always_comb begin
    redirect    = 1'b0;
    likely_miss = 1'b0;
    tgt         = slot_addr + ADDR_W'(4);
    case (kind)
      BK_COND: begin
        redirect = cond;
        if (cond) tgt = rel_target(slot_addr, imm);
      end
      BK_LIKELY: begin
        redirect    = cond;
        likely_miss = !cond;
        if (cond) tgt = rel_target(slot_addr, imm);
      end
      BK_JABS: begin
        redirect = 1'b1;
        tgt      = abs_target(slot_addr, jt);
      end
      BK_JREG: begin
        redirect = 1'b1;
        tgt      = jreg & ~ADDR_W'(3);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dspc_epc.sv
module dspc_epc
  import dspc_pkg::*;
(
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] cur_next,
  output logic [ADDR_W-1:0] epc_val
);
  assign epc_val = ret_addr(cur_pc, cur_next);
endmodule

// File: rtl/dspc_sequencer.sv
module dspc_sequencer
  import dspc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] EXC_VECTOR = 32'h0000_003C,
  parameter logic [ADDR_W-1:0] BOOT_ALT   = 32'h1000_0000,
  parameter logic [23:0]       BOOT_SIG   = 24'h3C1C10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       insn_word,
  input  logic [2:0]        br_kind,
  input  logic              br_cond,
  input  logic [15:0]       br_imm,
  input  logic [25:0]       jmp_tgt,
  input  logic [31:0]       jmp_reg,
  input  logic              exc_req,
  output logic [31:0]       pc,
  output logic [31:0]       pc_next,
  output logic              annul,
  output logic [31:0]       epc,
  output logic              mode_clr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic              boot_q, annul_q, mclr_q;
  logic [ADDR_W-1:0] pc_q, pn_q, epc_q;

  logic              redirect, likely_miss;
  logic [ADDR_W-1:0] tgt, epc_val;
  logic              live, exc_live, boot_hit;

  assign live     = !boot_q && !annul_q;
  assign exc_live = live && exc_req;
  assign boot_hit = (insn_word[31:8] == BOOT_SIG);

  dspc_target u_tgt (
    .kind(br_kind), .cond(br_cond), .imm(br_imm), .jt(jmp_tgt), .jreg(jmp_reg),
    .slot_addr(pn_q), .redirect(redirect), .likely_miss(likely_miss), .tgt(tgt)
  );

  dspc_epc u_epc (.cur_pc(pc_q), .cur_next(pn_q), .epc_val(epc_val));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q  <= 1'b1;
      pc_q    <= '0;
      pn_q    <= STEP;
      annul_q <= 1'b0;
      epc_q   <= '0;
      mclr_q  <= 1'b0;
    end else if (boot_q) begin
      boot_q <= 1'b0;
      mclr_q <= 1'b0;
      if (boot_hit) begin
        pc_q <= BOOT_ALT;
        pn_q <= BOOT_ALT + STEP;
      end
    end else begin
      pc_q   <= pn_q;
      mclr_q <= exc_live;
      if (exc_live) begin
        epc_q   <= epc_val;
        pn_q    <= EXC_VECTOR;
        annul_q <= 1'b1;
      end else if (annul_q) begin
        pn_q    <= pn_q + STEP;
        annul_q <= 1'b0;
      end else begin
        pn_q    <= redirect ? tgt : pn_q + STEP;
        annul_q <= likely_miss;
      end
    end
  end

  assign pc       = pc_q;
  assign pc_next  = pn_q;
  assign annul    = annul_q;
  assign epc      = epc_q;
  assign mode_clr = mclr_q;

  // R1
  pc_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_q |=> pc_q == $past(pn_q));

  // R1
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !exc_req && !redirect && !likely_miss) |=> pn_q == $past(pn_q) + STEP);

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pn_q[1:0] == 2'b00);

  // R3
  likely_annul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !exc_req && likely_miss) |=> annul_q);

  // R6
  exc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_live |=> (pn_q == EXC_VECTOR && annul_q && mclr_q));

  // R7
  annul_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_q && annul_q) |=> (!annul_q && !mclr_q));
endmodule

// File: tb/tb_dspc_sequencer.sv
`timescale 1ns/1ps
module tb_dspc_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn_word = '0;
  logic [2:0]  br_kind = '0;
  logic        br_cond = 1'b0;
  logic [15:0] br_imm = '0;
  logic [25:0] jmp_tgt = '0;
  logic [31:0] jmp_reg = '0;
  logic        exc_req = 1'b0;
  logic [31:0] pc, pc_next, epc;
  logic        annul, mode_clr;

  int checks = 0;
  int errors = 0;

  // model state
  logic [31:0] m_pc, m_pn, m_epc;
  logic        m_ann, m_clr;

  always #10 clk = ~clk;

  dspc_sequencer dut (
    .clk(clk), .rst_n(rst_n), .insn_word(insn_word), .br_kind(br_kind),
    .br_cond(br_cond), .br_imm(br_imm), .jmp_tgt(jmp_tgt), .jmp_reg(jmp_reg),
    .exc_req(exc_req), .pc(pc), .pc_next(pc_next), .annul(annul), .epc(epc),
    .mode_clr(mode_clr)
  );

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check32(tag, "pc", pc, m_pc);
    check32(tag, "pc_next", pc_next, m_pn);
    check32(tag, "annul", {31'd0, annul}, {31'd0, m_ann});
    check32(tag, "epc", epc, m_epc);
    check32(tag, "mode_clr", {31'd0, mode_clr}, {31'd0, m_clr});
  endtask

  // one executed instruction; called just after a negedge
  task automatic step(input logic [2:0] k, input logic c, input logic [15:0] im,
                      input logic [25:0] jt, input logic [31:0] jr, input logic ex);
    string tag;
    logic [31:0] npn;
    int signed off;
    br_kind = k; br_cond = c; br_imm = im; jmp_tgt = jt; jmp_reg = jr; exc_req = ex;
    npn = m_pn + 32'd4;
    if (m_ann) begin
      tag = "R7";
      m_ann = 1'b0;
      m_clr = 1'b0;
    end else if (ex) begin
      tag = "R6";
      m_epc = (m_pc + 32'd4) + ((m_pn == m_pc + 32'd4) ? 32'd0 : 32'd2);
      npn = 32'h3C;
      m_ann = 1'b1;
      m_clr = 1'b1;
    end else begin
      m_clr = 1'b0;
      m_ann = 1'b0;
      tag = "R1";
      off = 4 * int'($signed(im));
      if ((k == 3'd1 || k == 3'd2) && c) begin
        tag = (k == 3'd1) ? "R2" : "R3";
        npn = (m_pn + 32'(off)) & 32'hFFFF_FFFC;
      end else if (k == 3'd2) begin
        tag = "R3";
        m_ann = 1'b1;
      end else if (k == 3'd3) begin
        tag = "R4";
        npn = (m_pn & 32'hF000_0000) | (32'(jt) * 32'd4);
      end else if (k == 3'd4) begin
        tag = "R5";
        npn = {jr[31:2], 2'b00};
      end
    end
    m_pc = m_pn;
    m_pn = npn;
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset(input logic [31:0] first_word);
    @(negedge clk);
    rst_n = 1'b0;
    insn_word = first_word;
    @(negedge clk);
    @(negedge clk);
    m_pc = 32'd0; m_pn = 32'd4; m_ann = 1'b0; m_epc = 32'd0; m_clr = 1'b0;
    compare_all("R9");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (first_word[31:8] == 24'h3C1C10) begin
      m_pc = 32'h1000_0000; m_pn = 32'h1000_0004;
    end
    compare_all("R8");
  endtask

  task automatic sweep(input int seed);
    logic [15:0] imms [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'hFFFE, 16'h0003, 16'h0100};
    for (int k = 0; k <= 5; k++)
      for (int c = 0; c < 2; c++)
        for (int e = 0; e < 2; e++)
          for (int i = 0; i < 8; i++) begin
            step(3'(k), c[0], imms[i], 26'(32'h0155_5555 + 32'(i * 977 + seed)),
                 32'h8040_1237 + 32'(i * 13 + k), e[0] && (i % 3 == seed % 3));
            // a plain instruction between to exercise sequential / delay-slot paths
            if (i % 2 == 1) step(3'd0, 1'b0, 16'h0, 26'h0, 32'h0, 1'b0);
          end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(32'h2408_0001);          // R8 no signature: stays at 0
    sweep(1);
    do_reset(32'h3C1C_10AB);          // R8 signature: relocated start
    // R6 back-to-back: exception right after a taken branch (delay-slot marker)
    step(3'd1, 1'b1, 16'h0010, 26'h0, 32'h0, 1'b0);
    step(3'd0, 1'b0, 16'h0, 26'h0, 32'h0, 1'b1);
    step(3'd2, 1'b0, 16'h0, 26'h0, 32'h0, 1'b1); // R7 annulled: ignored
    sweep(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule